// File: doc/BRIEF.md
# Keyed-Service Watchdog Counter

This block is a watchdog down-counter that advances on a selectable tick: either the raw timer input tick or the divided timer output tick, both given as one-cycle enables in the bus clock domain. Software starts it by writing a start value to a write-only count register. From then on the counter must be refreshed before it runs out. It can be refreshed by writing the count register again or, when keyed servicing is on, by writing the key byte 5Ch to a service register.

Any write to the count or service register stays pending until the next watchdog tick, which applies it. While a write is pending a busy flag is raised, and power save may be entered only while that flag is low. A bad key, two key writes inside one watchdog tick, or the counter running out each put the block into a tripped state. The error output then stays high until reset. A freeze input stops the watchdog tick. A lock bit in the configuration register makes the configuration read-only until reset.

The controller has three states: `WD_IDLE`, `WD_RUN` and `WD_TRIP`.
- `WD_IDLE` moves to `WD_RUN` when a tick applies a pending count write.
- `WD_IDLE` and `WD_RUN` both move to `WD_TRIP` on a service fault.
- `WD_RUN` also moves to `WD_TRIP` when a tick finds the counter at zero with nothing pending.
- `WD_RUN` stays in `WD_RUN` on a reload or a decrement.
- `WD_TRIP` is left only by reset.

Top module: `wdk_watchdog`

## Requirements
- R1: After reset, the stored start value is 0Fh. The counter output is 0, and `wd_busy`, `wd_running` and `wd_err` are all low.
- R2: Before the first count write is applied, watchdog ticks leave the block idle, with `wd_running` low and the counter at 0.
- R3: A count write raises `wd_busy` in the next cycle. The next watchdog tick after it loads the written value, starts the watchdog (`wd_running` high) and clears `wd_busy`.
- R4: Each watchdog tick decrements the running counter when nothing is pending. A tick that finds the counter at 0 trips the block. `wd_err` then stays high until reset.
- R5: With keyed servicing enabled, writing 5Ch to the service register raises `wd_busy`. The next watchdog tick reloads the counter with the last count value written.
- R6: With keyed servicing enabled, a service write of any other value raises `wd_err` in the next cycle.
- R7: A second 5Ch write while an earlier one is still waiting for its tick raises `wd_err` in the next cycle.
- R8: With keyed servicing disabled, service writes are ignored: no busy, no error and no reload.
- R9: Configuration bit 0 selects the watchdog tick: 0 selects `tick_in` and 1 selects `tick_out`. The other tick has no effect.
- R10: While `freeze` is high, no watchdog tick occurs. The counter holds, and pending writes and `wd_busy` stay until a tick after freeze is released.
- R11: The configuration bits are: bit 0 tick select, bit 1 keyed-service enable, bit 2 lock. Once the lock bit is written as 1, later configuration writes are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_data | input | 3 | Configuration write data: select, key enable, lock |
| cnt_wr | input | 1 | Count register write strobe |
| svc_wr | input | 1 | Service register write strobe |
| wr_data | input | 8 | Write data for the count and service registers |
| tick_in | input | 1 | Raw timer input tick, one-cycle enable |
| tick_out | input | 1 | Timer output tick, one-cycle enable |
| freeze | input | 1 | Stops the watchdog tick while high |
| wd_count | output | 8 | Current watchdog counter value |
| wd_busy | output | 1 | A count or service write is waiting for its tick |
| wd_running | output | 1 | Watchdog started and not tripped |
| wd_err | output | 1 | Watchdog error, held until reset |

## Verification
Directed sequences come first.
- Counting with both tick selections shows whether the unselected tick leaks into the counter.
- Sequences with a correct key, a wrong key, a doubled key and a key sent while servicing is off show how the error path handles each kind of service write.
- Freeze is applied with writes pending, which shows that freeze holds both the count and the busy flag.
- A locked configuration followed by a new write shows that the lock holds.

A long stretch of random ticks, writes, freezes and configuration changes then follows, with a reset every few hundred cycles. A behavioural model compares the counter, busy, running and error outputs on every clock. This exposes any ordering slip when a write and a tick fall in the same cycle.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_state_e;

    // bit 0 tick select, bit 1 key enable, bit 2 lock
    typedef struct packed {
        logic lock;
        logic key_en;
        logic sel_out;
    } wdk_cfg_t;

    localparam int CFG_W = $bits(wdk_cfg_t);

endpackage

// File: rtl/wdk_cfg.sv
module wdk_cfg
    import wdk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    output wdk_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr && !cfg.lock) begin
            cfg <= wdk_cfg_t'(cfg_data);
        end
    end

    // R11: a locked configuration never changes again
    p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.lock |=> ($stable(cfg) && cfg.lock));

endmodule

// File: rtl/wdk_xfer.sv
module wdk_xfer #(
    parameter int         W         = 8,
    parameter logic [W-1:0] KEY     = 8'h5C,
    parameter logic [W-1:0] RST_VAL = 8'h0F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_wr,
    input  logic         svc_wr,
    input  logic [W-1:0] wr_data,
    input  logic         key_en,
    input  logic         wd_tick,
    output logic [W-1:0] reload_val,
    output logic         pend_load,
    output logic         pend_svc,
    output logic         busy,
    output logic         fault
);

    logic svc_take;
    logic key_ok;
    logic svc_dup;

    always_comb begin
        svc_take = svc_wr && key_en;
        key_ok   = (wr_data == KEY);
        svc_dup  = pend_svc && !wd_tick;
        fault    = svc_take && (!key_ok || svc_dup);
        busy     = pend_load || pend_svc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= RST_VAL;
            pend_load  <= 1'b0;
            pend_svc   <= 1'b0;
        end else begin
            if (cnt_wr) begin
                reload_val <= wr_data;
            end
            pend_load <= (pend_load && !wd_tick) || cnt_wr;
            pend_svc  <= (pend_svc && !wd_tick) || (svc_take && key_ok);
        end
    end

    // R3: a tick with no new write empties the pending slots
    p_busy_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wd_tick && !cnt_wr && !svc_wr) |=> !busy);

    // R8: with keying off, a lone service write leaves busy unchanged
    p_svc_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && !key_en && !cnt_wr && !busy) |=> !busy);

endmodule

// File: rtl/wdk_core.sv
module wdk_core
    import wdk_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wd_tick,
    input  logic         freeze,
    input  logic         pend_load,
    input  logic         pend_svc,
    input  logic [W-1:0] reload_val,
    input  logic         fault,
    output logic [W-1:0] count,
    output logic         running,
    output logic         err
);

    wd_state_e state;
    wd_state_e state_nx;
    logic      any_pend;
    logic      at_zero;

    always_comb begin
        any_pend = pend_load || pend_svc;
        at_zero  = (count == '0);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            WD_IDLE: begin
                if (fault) begin
                    state_nx = WD_TRIP;
                end else if (wd_tick && pend_load) begin
                    state_nx = WD_RUN;
                end
            end
            WD_RUN: begin
                if (fault) begin
                    state_nx = WD_TRIP;
                end else if (wd_tick && !any_pend && at_zero) begin
                    state_nx = WD_TRIP;
                end
            end
            WD_TRIP: state_nx = WD_TRIP;
            default: state_nx = WD_TRIP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wd_tick) begin
            unique case (state)
                WD_IDLE: begin
                    if (pend_load) begin
                        count <= reload_val;
                    end
                end
                WD_RUN: begin
                    if (any_pend) begin
                        count <= reload_val;
                    end else if (!at_zero) begin
                        count <= count - 1'b1;
                    end
                end
                default: count <= count;
            endcase
        end
    end

    // output decode
    always_comb begin
        running = (state == WD_RUN);
        err     = (state == WD_TRIP);
    end

    // R4: the error is held until reset
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R4: a plain tick takes exactly one off the counter
    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wd_tick && !any_pend && !at_zero && !fault)
        |=> (count == W'($past(count) - 1'b1)));

    // R2: without an applied load the block never starts
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_IDLE && !(wd_tick && pend_load)) |=> !running);

    // R10: freeze holds the counter
    p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(count));

endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
    import wdk_pkg::*;
#(
    parameter int             W       = 8,
    parameter logic [W-1:0]   KEY     = 8'h5C,
    parameter logic [W-1:0]   RST_VAL = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             cnt_wr,
    input  logic             svc_wr,
    input  logic [W-1:0]     wr_data,
    input  logic             tick_in,
    input  logic             tick_out,
    input  logic             freeze,
    output logic [W-1:0]     wd_count,
    output logic             wd_busy,
    output logic             wd_running,
    output logic             wd_err
);

    wdk_cfg_t     cfg;
    logic         wd_tick;
    logic [W-1:0] reload_val;
    logic         pend_load;
    logic         pend_svc;
    logic         fault;

    always_comb begin
        wd_tick = (cfg.sel_out ? tick_out : tick_in) && !freeze;
    end

    wdk_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .cfg      (cfg)
    );

    wdk_xfer #(
        .W       (W),
        .KEY     (KEY),
        .RST_VAL (RST_VAL)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_wr     (cnt_wr),
        .svc_wr     (svc_wr),
        .wr_data    (wr_data),
        .key_en     (cfg.key_en),
        .wd_tick    (wd_tick),
        .reload_val (reload_val),
        .pend_load  (pend_load),
        .pend_svc   (pend_svc),
        .busy       (wd_busy),
        .fault      (fault)
    );

    wdk_core #(
        .W (W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd_tick    (wd_tick),
        .freeze     (freeze),
        .pend_load  (pend_load),
        .pend_svc   (pend_svc),
        .reload_val (reload_val),
        .fault      (fault),
        .count      (wd_count),
        .running    (wd_running),
        .err        (wd_err)
    );

    // R6: a wrong key with keying on trips the block
    p_bad_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && cfg.key_en && wr_data != KEY) |=> wd_err);

    // R7: a second key before the tick trips the block
    p_dup_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && cfg.key_en && pend_svc && !wd_tick) |=> wd_err);

endmodule

// File: tb/wdk_watchdog_tb.sv
module wdk_watchdog_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_data = '0;
    logic       cnt_wr = 1'b0;
    logic       svc_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick_in = 1'b0;
    logic       tick_out = 1'b0;
    logic       freeze = 1'b0;
    logic [7:0] wd_count;
    logic       wd_busy;
    logic       wd_running;
    logic       wd_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_st = 0;      // 0 idle, 1 run, 2 trip
    int m_cnt = 0;
    int m_rel = 15;
    bit m_pl = 0, m_ps = 0;
    bit m_sel = 0, m_key = 0, m_lock = 0;

    always #5 clk = ~clk;

    wdk_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .cnt_wr(cnt_wr), .svc_wr(svc_wr), .wr_data(wr_data),
        .tick_in(tick_in), .tick_out(tick_out), .freeze(freeze),
        .wd_count(wd_count), .wd_busy(wd_busy),
        .wd_running(wd_running), .wd_err(wd_err)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_rel = 15;
            m_pl = 0; m_ps = 0; m_sel = 0; m_key = 0; m_lock = 0;
        end else begin
            bit tk, flt, take, good;
            int nst, ncnt;
            tk   = (m_sel ? tick_out : tick_in) && !freeze;
            take = svc_wr && m_key;
            good = (wr_data == 8'h5C);
            flt  = take && (!good || (m_ps && !tk));
            nst = m_st; ncnt = m_cnt;
            if (m_st != 2) begin
                if (tk) begin
                    if (m_st == 0 && m_pl) begin
                        ncnt = m_rel; nst = 1;
                    end else if (m_st == 1) begin
                        if (m_pl || m_ps) ncnt = m_rel;
                        else if (m_cnt == 0) nst = 2;
                        else ncnt = m_cnt - 1;
                    end
                end
                if (flt) nst = 2;
            end
            m_st = nst; m_cnt = ncnt;
            m_pl = (m_pl && !tk) || cnt_wr;
            m_ps = (m_ps && !tk) || (take && good);
            if (cnt_wr) m_rel = wr_data;
            if (cfg_wr && !m_lock) begin
                m_sel = cfg_data[0]; m_key = cfg_data[1]; m_lock = cfg_data[2];
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "count", wd_count, m_cnt);
            chk(cur_req, "busy", wd_busy, int'(m_pl || m_ps));
            chk(cur_req, "running", wd_running, int'(m_st == 1));
            chk(cur_req, "err", wd_err, int'(m_st == 2));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog timeout actual=%0d expected=0", cycles);
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask
    task automatic w_cfg(logic [2:0] v);
        cfg_wr = 1; cfg_data = v; @(negedge clk); cfg_wr = 0;
    endtask
    task automatic w_cnt(logic [7:0] v);
        cnt_wr = 1; wr_data = v; @(negedge clk); cnt_wr = 0;
    endtask
    task automatic w_svc(logic [7:0] v);
        svc_wr = 1; wr_data = v; @(negedge clk); svc_wr = 0;
    endtask
    task automatic p_in();
        tick_in = 1; @(negedge clk); tick_in = 0;
    endtask
    task automatic p_out();
        tick_out = 1; @(negedge clk); tick_out = 0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        cur_req = "R1";
        chk("R1", "count", wd_count, 0);
        chk("R1", "busy", wd_busy, 0);
        chk("R1", "running", wd_running, 0);
        chk("R1", "err", wd_err, 0);

        cur_req = "R2";
        p_in(); p_in(); p_in();
        chk("R2", "running", wd_running, 0);
        chk("R2", "count", wd_count, 0);

        cur_req = "R3";
        w_cnt(8'd5);
        chk("R3", "busy", wd_busy, 1);
        p_in();
        chk("R3", "running", wd_running, 1);
        chk("R3", "count", wd_count, 5);
        chk("R3", "busy", wd_busy, 0);

        cur_req = "R4";
        p_in(); p_in();
        chk("R4", "count", wd_count, 3);

        cur_req = "R9";
        w_cfg(3'b011);
        p_in();
        chk("R9", "count", wd_count, 3);
        p_out();
        chk("R9", "count", wd_count, 2);

        cur_req = "R5";
        w_svc(8'h5C);
        chk("R5", "busy", wd_busy, 1);
        p_out();
        chk("R5", "count", wd_count, 5);
        chk("R5", "busy", wd_busy, 0);

        cur_req = "R10";
        freeze = 1;
        p_out(); p_out();
        chk("R10", "count", wd_count, 5);
        w_svc(8'h5C);
        p_out();
        chk("R10", "busy", wd_busy, 1);
        freeze = 0;
        p_out();
        chk("R10", "busy", wd_busy, 0);
        chk("R10", "count", wd_count, 5);

        cur_req = "R7";
        w_svc(8'h5C); w_svc(8'h5C);
        chk("R7", "err", wd_err, 1);
        repeat (3) @(negedge clk);
        chk("R4", "err sticky", wd_err, 1);

        do_reset();
        cur_req = "R8";
        w_cfg(3'b000);
        w_cnt(8'd3);
        p_in();
        w_svc(8'h5C);
        chk("R8", "busy", wd_busy, 0);
        w_svc(8'h00);
        chk("R8", "err", wd_err, 0);
        p_in();
        chk("R8", "count", wd_count, 2);

        cur_req = "R6";
        w_cfg(3'b010);
        w_svc(8'h12);
        chk("R6", "err", wd_err, 1);

        do_reset();
        cur_req = "R11";
        w_cfg(3'b110);
        w_cfg(3'b001);
        w_cnt(8'd4);
        p_in();
        chk("R11", "running", wd_running, 1);
        chk("R11", "count", wd_count, 4);
        p_out();
        chk("R11", "count", wd_count, 4);
        w_svc(8'h33);
        chk("R11", "err", wd_err, 1);

        do_reset();
        cur_req = "R4";
        w_cnt(8'd2);
        p_in(); p_in(); p_in();
        chk("R4", "count", wd_count, 0);
        chk("R4", "err", wd_err, 0);
        p_in();
        chk("R4", "err expiry", wd_err, 1);
        repeat (5) @(negedge clk);
        chk("R4", "err sticky", wd_err, 1);

        cur_req = "RND";
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) do_reset();
            tick_in  = ($urandom % 3) == 0;
            tick_out = ($urandom % 5) == 0;
            freeze   = ($urandom % 10) == 0;
            cnt_wr   = ($urandom % 20) == 0;
            svc_wr   = ($urandom % 8) == 0;
            wr_data  = (($urandom % 5) != 0) ? 8'h5C : 8'($urandom % 16);
            if (cnt_wr) wr_data = 8'($urandom % 12);
            cfg_wr   = ($urandom % 40) == 0;
            cfg_data = 3'($urandom % 4) | ((($urandom % 4) == 0) ? 3'b100 : 3'b000);
            @(negedge clk);
        end
        tick_in = 0; tick_out = 0; freeze = 0; cnt_wr = 0; svc_wr = 0; cfg_wr = 0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule